// File: doc/BRIEF.md
# Receive destination address filter

This block sits in the receive path of an Ethernet controller and decides, frame by frame, whether the frame should be kept. It looks only at the six destination address bytes at the head of each frame. Those bytes arrive one per cycle, and the first byte is marked by a start strobe. One cycle after the sixth byte, the block raises a single-cycle decision. The decision carries an accept flag, a table-hit flag and the index of the table entry that hit.

Software programs the filter through a simple word-wide register port. The port gives access to a mode register, an entry-enable mask and a table of 16 station addresses. Each address occupies two words. The block holds two copies of its settings. The software-visible copy changes on every write. The copy that governs a frame is captured when that frame starts, so reprogramming never disturbs a frame that is already being examined.

Top module: `daf_top`

## Requirements
- R1: After reset, every register reads 0 and the outputs `dec_vld`, `dec_accept`, `dec_hit` and `dec_hit_idx` are 0.
- R2: Register map, all word aligned; any other address reads 0 and writes to it are ignored.
  - Mode register at 0x00, which keeps only bits 0, 1, 2 and 4 and reads the rest as 0.
  - Entry-enable register at 0x04, one bit per entry, entry 0 in bit 0.
  - For entry x, the upper word at 0x08+8·x and the lower word at 0x0C+8·x. The lower word keeps bits 31:16 and reads bits 15:0 as 0.
- R3: Address byte order is fixed. The first received byte is compared with bits 31:24 of the upper word, down to the fourth byte with bits 7:0. The fifth byte is compared with bits 31:24 of the lower word and the sixth with bits 23:16. With mode bit 4 set, a frame whose six bytes all equal an enabled entry gives `dec_hit`=1 and `dec_accept`=1.
- R4: An entry whose enable bit is 0 never hits, whatever its stored address.
- R5: A unicast frame (bit 0 of the first byte is 0) is accepted whenever mode bit 0 is set.
- R6: A multicast frame (bit 0 of the first byte is 1, and the address is not all-ones) is accepted whenever mode bit 1 is set.
- R7: A broadcast frame (all six bytes 0xFF) is accepted whenever mode bit 2 is set. It counts as neither unicast nor multicast.
- R8: Decision timing.
  - `dec_vld` is 1 for exactly one cycle, in the cycle after the sixth accepted byte.
  - Idle cycles between bytes (`rx_byte_vld`=0) are allowed.
  - Bytes after the sixth, up to the next start strobe, are ignored.
  - `dec_accept` and `dec_hit` are 0 whenever `dec_vld` is 0.
- R9: A start strobe (`rx_sof`=1 with `rx_byte_vld`=1) always begins a new address, even if the previous one is unfinished. The unfinished address produces no decision.
- R10: Register writes made while an address is being received take effect from the next start strobe. This includes a write in the same cycle as that frame's own start strobe.
- R11: `dec_hit` is 1 only when mode bit 4 is set and an enabled entry matches. `dec_hit_idx` is then the lowest matching entry index, and otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| rx_sof | input | 1 | Marks the first destination byte of a frame |
| rx_byte_vld | input | 1 | `rx_byte` carries a destination byte this cycle |
| rx_byte | input | 8 | Destination address byte |
| dec_vld | output | 1 | Decision valid (one cycle) |
| dec_accept | output | 1 | Frame accepted |
| dec_hit | output | 1 | An enabled table entry matched under exact compare |
| dec_hit_idx | output | 4 | Lowest matching entry index |

## Verification
Register programming and address comparison can fall in the same cycle. The sharpest case is a write that lands together with a frame's start strobe or with one of its middle bytes. The bench provokes both by raising `reg_wr` on chosen byte slots of a frame. It judges the result against a behavioural model in which the frame uses the settings captured at its start strobe, and the changed setting is seen only by the following frame. A second overlap, a new start strobe cutting into an unfinished address, is judged the same way, and the model is compared with the outputs on every clock.

// File: rtl/daf_pkg.sv
`timescale 1ns/1ps
package daf_pkg;
  localparam int MAC_BYTES = 6;
  localparam int MAC_W     = 8 * MAC_BYTES;
  localparam int CNT_W     = 3;

  localparam int BIT_UNI   = 0;
  localparam int BIT_MULTI = 1;
  localparam int BIT_BCAST = 2;
  localparam int BIT_EXACT = 4;

  typedef struct packed {
    logic exact;
    logic bcast;
    logic multi;
    logic uni;
  } fmode_t;

  function automatic logic [31:0] mode2word(fmode_t m);
    logic [31:0] w;
    w = '0;
    w[BIT_UNI]   = m.uni;
    w[BIT_MULTI] = m.multi;
    w[BIT_BCAST] = m.bcast;
    w[BIT_EXACT] = m.exact;
    return w;
  endfunction
endpackage

// File: rtl/daf_regs.sv
`timescale 1ns/1ps
module daf_regs
  import daf_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int AW    = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr,
  input  logic [AW-1:0]                   addr,
  input  logic [31:0]                     wdata,
  input  logic                            snap,
  output logic [31:0]                     rdata,
  output fmode_t                          eff_mode,
  output logic [N_ENT-1:0]                eff_en,
  output logic [N_ENT-1:0][MAC_W-1:0]     eff_addr
);
  localparam int MODE_OFS   = 0;
  localparam int EN_OFS     = 4;
  localparam int ENT_BASE   = 8;
  localparam int ENT_STRIDE = 8;
  localparam int LO_OFS     = 4;
  localparam int LO_W       = MAC_W - 32;

  fmode_t                      mode_q, mode_d, act_mode_q;
  logic [N_ENT-1:0]            en_q, en_d, act_en_q;
  logic [N_ENT-1:0][31:0]      hi_q, hi_d;
  logic [N_ENT-1:0][LO_W-1:0]  lo_q, lo_d;
  logic [N_ENT-1:0][MAC_W-1:0] live_addr, act_addr_q;
  logic [N_ENT-1:0]            sel_hi, sel_lo;
  logic                        sel_mode, sel_en;

  assign sel_mode = wr && (addr == AW'(MODE_OFS));
  assign sel_en   = wr && (addr == AW'(EN_OFS));

  for (genvar i = 0; i < N_ENT; i++) begin : g_dec
    assign sel_hi[i]    = wr && (addr == AW'(ENT_BASE + ENT_STRIDE * i));
    assign sel_lo[i]    = wr && (addr == AW'(ENT_BASE + ENT_STRIDE * i + LO_OFS));
    assign live_addr[i] = {hi_q[i], lo_q[i]};
  end

  // next-state of the software-visible copy
  always_comb begin
    mode_d = mode_q;
    if (sel_mode) begin
      mode_d.uni   = wdata[BIT_UNI];
      mode_d.multi = wdata[BIT_MULTI];
      mode_d.bcast = wdata[BIT_BCAST];
      mode_d.exact = wdata[BIT_EXACT];
    end
    en_d = sel_en ? wdata[N_ENT-1:0] : en_q;
    for (int i = 0; i < N_ENT; i++) begin
      hi_d[i] = sel_hi[i] ? wdata : hi_q[i];
      lo_d[i] = sel_lo[i] ? wdata[31:32-LO_W] : lo_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_q   <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      mode_q <= mode_d;
      en_q   <= en_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  // frame copy, captured on a start strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode_q <= '0;
      act_en_q   <= '0;
      act_addr_q <= '0;
    end else if (snap) begin
      act_mode_q <= mode_q;
      act_en_q   <= en_q;
      act_addr_q <= live_addr;
    end
  end

  assign eff_mode = snap ? mode_q    : act_mode_q;
  assign eff_en   = snap ? en_q      : act_en_q;
  assign eff_addr = snap ? live_addr : act_addr_q;

  always_comb begin
    rdata = '0;
    if (addr == AW'(MODE_OFS)) rdata = mode2word(mode_q);
    if (addr == AW'(EN_OFS))   rdata = 32'(en_q);
    for (int i = 0; i < N_ENT; i++) begin
      if (addr == AW'(ENT_BASE + ENT_STRIDE * i))          rdata = hi_q[i];
      if (addr == AW'(ENT_BASE + ENT_STRIDE * i + LO_OFS)) rdata = {lo_q[i], {(32-LO_W){1'b0}}};
    end
  end
endmodule

// File: rtl/daf_track.sv
`timescale 1ns/1ps
module daf_track
  import daf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  logic             sof,
  input  logic [7:0]       byte_in,
  output logic             take,
  output logic             restart,
  output logic [CNT_W-1:0] idx,
  output logic             last,
  output logic             ff_nxt,
  output logic             grp_nxt
);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(MAC_BYTES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ff_q, grp_q;

  assign restart = vld && sof;
  assign take    = restart || (vld && (cnt_q != '0) && (cnt_q < CNT_END));
  assign idx     = restart ? '0 : cnt_q;
  assign last    = take && (idx == CNT_END - 1'b1);

  always_comb begin
    cnt_d   = take ? idx + 1'b1 : cnt_q;
    ff_nxt  = (restart ? 1'b1 : ff_q) && (byte_in == 8'hFF);
    grp_nxt = (idx == '0) ? byte_in[0] : grp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ff_q  <= 1'b0;
      grp_q <= 1'b0;
    end else if (take) begin
      cnt_q <= cnt_d;
      ff_q  <= ff_nxt;
      grp_q <= grp_nxt;
    end
  end
endmodule

// File: rtl/daf_match.sv
`timescale 1ns/1ps
module daf_match
  import daf_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        take,
  input  logic                        restart,
  input  logic [CNT_W-1:0]            idx,
  input  logic [7:0]                  byte_in,
  input  logic [N_ENT-1:0]            eff_en,
  input  logic [N_ENT-1:0][MAC_W-1:0] eff_addr,
  output logic [N_ENT-1:0]            hit_vec
);
  logic [CNT_W-1:0] sel;
  assign sel = CNT_W'(MAC_BYTES - 1) - idx;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic flag_q, flag_d, eq;
    assign eq = (eff_addr[i][8*sel +: 8] == byte_in);

    always_comb begin
      flag_d = flag_q;
      if (take) flag_d = (restart ? 1'b1 : flag_q) && eq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag_q <= 1'b0;
      else if (take) flag_q <= flag_d;
    end

    assign hit_vec[i] = flag_d && eff_en[i];
  end
endmodule

// File: rtl/daf_decide.sv
`timescale 1ns/1ps
module daf_decide
  import daf_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             last,
  input  logic [N_ENT-1:0] hit_vec,
  input  fmode_t           mode,
  input  logic             ff,
  input  logic             grp,
  output logic             vld_o,
  output logic             acc_o,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             is_b, is_m, is_u, any_hit, acc;
  logic [IDX_W-1:0] enc;
  logic             vld_d, acc_d, hit_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    enc = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) enc = IDX_W'(i);
    end
    is_b    = ff;
    is_m    = grp && !ff;
    is_u    = !grp;
    any_hit = mode.exact && (|hit_vec);
    acc     = any_hit || (is_u && mode.uni) || (is_m && mode.multi) || (is_b && mode.bcast);
    vld_d   = last;
    acc_d   = last && acc;
    hit_d   = last && any_hit;
    idx_d   = (last && any_hit) ? enc : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      acc_o <= 1'b0;
      hit_o <= 1'b0;
      idx_o <= '0;
    end else begin
      vld_o <= vld_d;
      acc_o <= acc_d;
      hit_o <= hit_d;
      idx_o <= idx_d;
    end
  end
endmodule

// File: rtl/daf_top.sv
`timescale 1ns/1ps
module daf_top
  import daf_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int AW    = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             rx_sof,
  input  logic             rx_byte_vld,
  input  logic [7:0]       rx_byte,
  output logic             dec_vld,
  output logic             dec_accept,
  output logic             dec_hit,
  output logic [IDX_W-1:0] dec_hit_idx
);
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  fmode_t                      eff_mode;
  logic [N_ENT-1:0]            eff_en, hit_vec;
  logic [N_ENT-1:0][MAC_W-1:0] eff_addr;
  logic                        take, restart, last, ff_nxt, grp_nxt;
  logic [CNT_W-1:0]            idx;

  daf_track u_track (
    .clk(clk), .rst_n(rst_i_n), .vld(rx_byte_vld), .sof(rx_sof), .byte_in(rx_byte),
    .take(take), .restart(restart), .idx(idx), .last(last),
    .ff_nxt(ff_nxt), .grp_nxt(grp_nxt)
  );

  daf_regs #(.N_ENT(N_ENT), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .snap(restart), .rdata(reg_rdata), .eff_mode(eff_mode), .eff_en(eff_en),
    .eff_addr(eff_addr)
  );

  daf_match #(.N_ENT(N_ENT)) u_match (
    .clk(clk), .rst_n(rst_i_n), .take(take), .restart(restart), .idx(idx),
    .byte_in(rx_byte), .eff_en(eff_en), .eff_addr(eff_addr), .hit_vec(hit_vec)
  );

  daf_decide #(.N_ENT(N_ENT)) u_decide (
    .clk(clk), .rst_n(rst_i_n), .last(last), .hit_vec(hit_vec), .mode(eff_mode),
    .ff(ff_nxt), .grp(grp_nxt), .vld_o(dec_vld), .acc_o(dec_accept),
    .hit_o(dec_hit), .idx_o(dec_hit_idx)
  );
endmodule

// File: rtl/daf_chk.sv
`timescale 1ns/1ps
module daf_chk #(
  parameter int N_ENT = 16,
  parameter int AW    = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [AW-1:0]    reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             rx_byte_vld,
  input logic             dec_vld,
  input logic             dec_accept,
  input logic             dec_hit,
  input logic [IDX_W-1:0] dec_hit_idx
);
  // R8
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |=> !dec_vld);

  // R8
  vld_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> $past(rx_byte_vld));

  // R8
  quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld |-> (!dec_accept && !dec_hit));

  // R11
  hit_implies_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |-> dec_accept);

  // R11
  idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_hit |-> (dec_hit_idx == '0));

  // R2
  mode_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == '0) |=>
      (reg_addr != '0 || reg_rdata == ($past(reg_wdata) & 32'h0000_0017)));
endmodule

bind daf_top daf_chk #(.N_ENT(N_ENT), .AW(AW)) u_chk (.*);

// File: tb/sim_daf_top.sv
`timescale 1ns/1ps
module sim_daf_top;
  localparam int CLK_P = 10;
  localparam int N_ENT = 16;
  localparam int AW    = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        rx_sof, rx_byte_vld;
  logic [7:0]  rx_byte;
  logic        dec_vld, dec_accept, dec_hit;
  logic [3:0]  dec_hit_idx;

  always #(CLK_P/2) clk = ~clk;

  daf_top #(.N_ENT(N_ENT), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_sof(rx_sof),
    .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte), .dec_vld(dec_vld),
    .dec_accept(dec_accept), .dec_hit(dec_hit), .dec_hit_idx(dec_hit_idx)
  );

  int    total = 0;
  int    bad   = 0;
  string cur_req = "R1";

  // behavioural reference model
  logic [31:0] m_cmd, a_cmd;
  logic [15:0] m_en, a_en;
  logic [31:0] m_hi[N_ENT], a_hi[N_ENT];
  logic [15:0] m_lo[N_ENT], a_lo[N_ENT];
  int          m_cnt;
  logic [7:0]  bq[$];
  logic        e_vld, e_acc, e_hit;
  int          e_idx;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmd = 0; m_en = 0; a_cmd = 0; a_en = 0; m_cnt = 0;
      for (int i = 0; i < N_ENT; i++) begin
        m_hi[i] = 0; m_lo[i] = 0; a_hi[i] = 0; a_lo[i] = 0;
      end
      bq.delete();
      e_vld = 0; e_acc = 0; e_hit = 0; e_idx = 0;
    end else begin
      e_vld = 0; e_acc = 0; e_hit = 0; e_idx = 0;
      if (rx_byte_vld && (rx_sof || (m_cnt > 0 && m_cnt < 6))) begin
        if (rx_sof) begin
          a_cmd = m_cmd; a_en = m_en; a_hi = m_hi; a_lo = m_lo;
          m_cnt = 0; bq.delete();
        end
        bq.push_back(rx_byte);
        m_cnt++;
        if (m_cnt == 6) begin
          logic [47:0] d;
          logic bc, mc, uc, h;
          int   hi_idx;
          d  = {bq[0], bq[1], bq[2], bq[3], bq[4], bq[5]};
          bc = (d == 48'hFFFF_FFFF_FFFF);
          mc = bq[0][0] && !bc;
          uc = !bq[0][0];
          h = 0; hi_idx = 0;
          for (int i = N_ENT - 1; i >= 0; i--)
            if (a_en[i] && {a_hi[i], a_lo[i]} == d) begin h = 1; hi_idx = i; end
          h = h && a_cmd[4];
          e_vld = 1;
          e_hit = h;
          e_idx = h ? hi_idx : 0;
          e_acc = h || (uc && a_cmd[0]) || (mc && a_cmd[1]) || (bc && a_cmd[2]);
        end
      end
      if (reg_wr) begin
        if (reg_addr == 8'h00) m_cmd = reg_wdata & 32'h17;
        if (reg_addr == 8'h04) m_en  = reg_wdata[15:0];
        for (int i = 0; i < N_ENT; i++) begin
          if (reg_addr == 8'(8 + 8*i))  m_hi[i] = reg_wdata;
          if (reg_addr == 8'(12 + 8*i)) m_lo[i] = reg_wdata[31:16];
        end
      end
    end
  end

  // per-cycle comparison and decision capture
  logic       got_dec, g_acc, g_hit;
  logic [3:0] g_idx;

  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if ({dec_vld, dec_accept, dec_hit, dec_hit_idx} !== {e_vld, e_acc, e_hit, 4'(e_idx)}) begin
        bad++;
        $display("FAIL %s per-cycle: got vld=%0b acc=%0b hit=%0b idx=%0d exp vld=%0b acc=%0b hit=%0b idx=%0d",
                 cur_req, dec_vld, dec_accept, dec_hit, dec_hit_idx, e_vld, e_acc, e_hit, e_idx);
      end
      if (dec_vld) begin
        got_dec = 1; g_acc = dec_accept; g_hit = dec_hit; g_idx = dec_hit_idx;
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    total++;
    if (reg_rdata !== exp) begin
      bad++;
      $display("FAIL %s read 0x%02h: got 0x%08h exp 0x%08h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic send(input logic [47:0] d, input int gap, input int extra,
                      input int nbytes, input int wr_at,
                      input logic [7:0] wa, input logic [31:0] wd);
    got_dec = 0;
    for (int k = 0; k < nbytes; k++) begin
      @(negedge clk);
      rx_byte_vld = 1; rx_sof = (k == 0); rx_byte = d[47-8*k -: 8];
      reg_wr = (k == wr_at); reg_addr = wa; reg_wdata = wd;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        rx_byte_vld = 0; rx_sof = 0; reg_wr = 0;
      end
    end
    for (int e = 0; e < extra; e++) begin
      @(negedge clk);
      rx_byte_vld = 1; rx_sof = 0; rx_byte = 8'(8'h5A + e); reg_wr = 0;
    end
    @(negedge clk);
    rx_byte_vld = 0; rx_sof = 0; reg_wr = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input logic [47:0] d);
    send(d, 0, 0, 6, -1, 8'h00, 32'h0);
  endtask

  task automatic expect_dec(input logic acc, input logic hit, input logic [3:0] idx, input string tag);
    total++;
    if (!got_dec || g_acc !== acc || g_hit !== hit || g_idx !== idx) begin
      bad++;
      $display("FAIL %s decision: got seen=%0b acc=%0b hit=%0b idx=%0d exp acc=%0b hit=%0b idx=%0d",
               tag, got_dec, g_acc, g_hit, g_idx, acc, hit, idx);
    end
  endtask

  localparam logic [47:0] E0 = 48'h0A1B_2C3D_4E5F;
  localparam logic [47:0] E3 = 48'h5A6B_7C8D_9EAF;
  localparam logic [47:0] E7 = 48'h0123_4567_89AB;
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC = 48'h0311_2233_4455;
  localparam logic [47:0] UO = 48'h0611_2233_4455;

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    rx_sof = 0; rx_byte_vld = 0; rx_byte = 0;
    got_dec = 0; g_acc = 0; g_hit = 0; g_idx = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    cur_req = "R1";
    total++;
    if ({dec_vld, dec_accept, dec_hit, dec_hit_idx} !== 7'b0) begin
      bad++; $display("FAIL R1 outputs after reset: got %b exp 0", {dec_vld, dec_accept, dec_hit, dec_hit_idx});
    end
    rd_chk(8'h00, 32'h0, "R1");
    rd_chk(8'h04, 32'h0, "R1");
    rd_chk(8'h08, 32'h0, "R1");
    rd_chk(8'h0C, 32'h0, "R1");

    // R2 programming and readback
    cur_req = "R2";
    wr(8'h08, 32'h0A1B2C3D); wr(8'h0C, 32'h4E5F1234);
    wr(8'h20, 32'h5A6B7C8D); wr(8'h24, 32'h9EAF0000);
    wr(8'h30, 32'h5A6B7C8D); wr(8'h34, 32'h9EAFFFFF);
    wr(8'h40, 32'h01234567); wr(8'h44, 32'h89AB0000);
    wr(8'h04, 32'hFFFF00A9);
    wr(8'h00, 32'hFFFFFFFF);
    wr(8'h86, 32'hFFFFFFFF);
    rd_chk(8'h0C, 32'h4E5F0000, "R2");
    rd_chk(8'h08, 32'h0A1B2C3D, "R2");
    rd_chk(8'h04, 32'h000000A9, "R2");
    rd_chk(8'h00, 32'h00000017, "R2");
    rd_chk(8'h10, 32'h00000000, "R2");
    rd_chk(8'h86, 32'h00000000, "R2");

    // exact compare plus broadcast
    wr(8'h00, 32'h14);
    cur_req = "R3"; frame(E0); expect_dec(1, 1, 0, "R3");
    cur_req = "R3"; frame(48'h0A1B_2C3D_4E50); expect_dec(0, 0, 0, "R3");
    cur_req = "R3"; frame(E7); expect_dec(1, 1, 7, "R3");
    cur_req = "R11"; frame(E3); expect_dec(1, 1, 3, "R11");
    cur_req = "R7"; frame(BC); expect_dec(1, 0, 0, "R7");
    cur_req = "R6"; frame(MC); expect_dec(0, 0, 0, "R6");

    // R4 disabled entries
    cur_req = "R4";
    wr(8'h04, 32'h00A8); frame(E0); expect_dec(0, 0, 0, "R4");
    wr(8'h04, 32'h00A0); frame(E3); expect_dec(1, 1, 5, "R4");
    wr(8'h04, 32'h00A9);

    // R6 / R5 mode bits
    cur_req = "R6"; wr(8'h00, 32'h16); frame(MC); expect_dec(1, 0, 0, "R6");
    cur_req = "R5"; frame(UO); expect_dec(0, 0, 0, "R5");
    cur_req = "R5"; wr(8'h00, 32'h17); frame(UO); expect_dec(1, 0, 0, "R5");

    // R11 compare off: no hit reported
    cur_req = "R11"; wr(8'h00, 32'h01); frame(E3); expect_dec(1, 0, 0, "R11");
    cur_req = "R7"; frame(BC); expect_dec(0, 0, 0, "R7");
    cur_req = "R7"; wr(8'h00, 32'h02); frame(BC); expect_dec(0, 0, 0, "R7");

    // R8 gaps and trailing bytes
    cur_req = "R8"; wr(8'h00, 32'h14);
    send(E0, 2, 0, 6, -1, 8'h00, 32'h0); expect_dec(1, 1, 0, "R8");
    send(E7, 1, 4, 6, -1, 8'h00, 32'h0); expect_dec(1, 1, 7, "R8");

    // R9 restart on a new strobe
    cur_req = "R9";
    send(E0, 0, 0, 3, -1, 8'h00, 32'h0);
    total++;
    if (got_dec) begin bad++; $display("FAIL R9 partial address decided: got 1 exp 0"); end
    frame(MC); expect_dec(0, 0, 0, "R9");

    // R10 writes during reception
    cur_req = "R10";
    send(MC, 0, 0, 6, 2, 8'h00, 32'h16); expect_dec(0, 0, 0, "R10");
    frame(MC); expect_dec(1, 0, 0, "R10");
    send(MC, 0, 0, 6, 0, 8'h00, 32'h14); expect_dec(1, 0, 0, "R10");
    frame(MC); expect_dec(0, 0, 0, "R10");
    send(E0, 1, 0, 6, 3, 8'h04, 32'h0); expect_dec(1, 1, 0, "R10");
    frame(E0); expect_dec(0, 0, 0, "R10");
    wr(8'h04, 32'h00A9);

    // mixed traffic against the model
    cur_req = "R3/R5/R6/R7";
    for (int n = 0; n < 40; n++) begin
      logic [47:0] d;
      wr(8'h00, $urandom() & 32'h17);
      case ($urandom() % 5)
        0: d = E0;
        1: d = E3;
        2: d = E7;
        3: d = BC;
        default: d = {$urandom(), 16'($urandom())};
      endcase
      send(d, $urandom() % 2, $urandom() % 3, 6, -1, 8'h00, 32'h0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule